// File: doc/BRIEF.md
# Store-to-Load Byte Bypass for a Registered-Output Cache Data RAM

This block sits beside the data RAM of a two-stage cache pipeline. The RAM has a registered read port, so the read data for a load becomes visible one cycle after the load address is presented. Stores that hit the cache are written at a clock edge. Two writes can therefore be missing from the value the RAM returns. One is the write that happened at the same edge where the load address was sampled, because the read sees the value from before the write. The other is the write still waiting on the store port while the read data is on the output.

The block remembers the first of those two writes in a register and takes the second straight from the store port. For each byte it picks the value a load would have seen if every hitting store had already reached the RAM. The store on the port is younger and wins over the registered one. The registered one wins over the RAM. A store that zeroes a row sets every byte of that row to zero, whatever its byte mask says. Stores that miss the cache never write the RAM, so they are never forwarded. Forwarding needs the row index and the way to both match the load.

Top module: `stld_bypass`

## Requirements
- R1: `ld_rvalid` is low while reset is held, and in every later cycle it equals the value `ld_valid` had one cycle earlier.
- R2: If no forwarding store matches the load, `ld_data` equals `ram_rdata` exactly.
- R3: A store on the port with `st_valid` and `st_hit` high, in the cycle `ld_rvalid` is high, whose row and way equal the load's, replaces byte k of `ld_data` (bits 8k+7 down to 8k) with byte k of `st_data` for each set bit k of `st_mask`.
- R4: A hitting store that was on the port in the same cycle the load address was presented, with matching row and way, supplies its masked bytes to `ld_data` one cycle later.
- R5: Where both stores cover the same byte, the store currently on the port wins. A byte covered only by the earlier store keeps the earlier store's value.
- R6: A store with `st_hit` low is never forwarded. The load data for that row comes from the RAM and any other hitting store.
- R7: A store whose way differs from the load's way is not forwarded, even if the row matches.
- R8: A store with `st_zero` high forwards zero in every byte of the row, ignoring `st_mask` and `st_data`.
- R9: For any interleaving of loads and hitting stores, `ld_data` with `ld_rvalid` high equals the row value after all stores up to and including the one on the port that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store write presented this cycle, written at the next edge |
| st_hit | input | 1 | Store hit the cache; only hitting stores write the RAM |
| st_zero | input | 1 | Store zeroes the whole row |
| st_way | input | WAY_BITS | Way written by the store |
| st_row | input | ROW_BITS | Row index written by the store |
| st_mask | input | DATA_BYTES | Byte enables of the store, bit k covers byte k |
| st_data | input | 8*DATA_BYTES | Store data |
| ld_valid | input | 1 | Load address presented this cycle |
| ld_way | input | WAY_BITS | Way hit by the load |
| ld_row | input | ROW_BITS | Row index read by the load |
| ram_rdata | input | 8*DATA_BYTES | Registered RAM output, one cycle after the address |
| ld_rvalid | output | 1 | Load data valid this cycle |
| ld_data | output | 8*DATA_BYTES | Load data with in-flight stores merged in |

## Verification
The checker follows the load handshake on every cycle. It also checks that a load with no matching store passes the RAM data through. A matching full-mask store on the port must take the whole word, a matching zeroing store must force zero, and a full-mask registered store must show through when the port has no match. Partial masks, the overlap order between the two stores, and stores that miss or target another way can only be seen in the bench. The bench shows them against a reference row image across directed pairs and a long sweep over a tiny row and way space.

// File: rtl/stld_pkg.sv
package stld_pkg;

   typedef enum logic [1:0] {
      BSRC_RAM  = 2'd0,
      BSRC_OLD  = 2'd1,
      BSRC_NEW  = 2'd2,
      BSRC_ZERO = 2'd3
   } bsrc_e;

   // Youngest writer of a byte wins; a zeroing writer supplies zero.
   function automatic bsrc_e pick_src(input logic new_hit, input logic new_zero,
                                      input logic old_hit, input logic old_zero);
      if (new_hit) return new_zero ? BSRC_ZERO : BSRC_NEW;
      if (old_hit) return old_zero ? BSRC_ZERO : BSRC_OLD;
      return BSRC_RAM;
   endfunction

endpackage

// File: rtl/stld_pipe_reg.sv
module stld_pipe_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_pay,
   output logic         out_vld,
   output logic [W-1:0] out_pay
);
   if (W < 1) begin : g_bad_w
      $error("stld_pipe_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_pay <= '0;
      end else begin
         out_vld <= in_vld;
         out_pay <= in_pay;
      end
   end
endmodule

// File: rtl/stld_match.sv
module stld_match #(
   parameter int NB       = 8,
   parameter int ROW_BITS = 6,
   parameter int WAYS     = 2,
   parameter int WAY_BITS = 1
) (
   input  logic                vld,
   input  logic                zero,
   input  logic [WAY_BITS-1:0] way,
   input  logic [ROW_BITS-1:0] row,
   input  logic [NB-1:0]       mask,
   input  logic [WAY_BITS-1:0] ld_way,
   input  logic [ROW_BITS-1:0] ld_row,
   output logic [NB-1:0]       byte_hit
);
   logic way_eq;
   logic row_hit;

   if (WAYS > 1) begin : g_multi_way
      assign way_eq = (way == ld_way);
   end else begin : g_single_way
      logic unused_way;
      assign unused_way = ^{way, ld_way};
      assign way_eq     = 1'b1;
   end

   assign row_hit = vld && way_eq && (row == ld_row);

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign byte_hit[b] = row_hit && (zero || mask[b]);
   end
endmodule

// File: rtl/stld_merge.sv
module stld_merge
   import stld_pkg::*;
#(
   parameter int NB = 8
) (
   input  logic [8*NB-1:0] ram_rdata,
   input  logic [8*NB-1:0] old_data,
   input  logic [8*NB-1:0] new_data,
   input  logic [NB-1:0]   old_hit,
   input  logic [NB-1:0]   new_hit,
   input  logic            old_zero,
   input  logic            new_zero,
   output logic [8*NB-1:0] data
);
   for (genvar b = 0; b < NB; b++) begin : g_byte
      bsrc_e src;
      assign src = pick_src(new_hit[b], new_zero, old_hit[b], old_zero);
      always_comb begin
         unique case (src)
            BSRC_NEW:  data[8*b +: 8] = new_data[8*b +: 8];
            BSRC_OLD:  data[8*b +: 8] = old_data[8*b +: 8];
            BSRC_ZERO: data[8*b +: 8] = 8'h00;
            default:   data[8*b +: 8] = ram_rdata[8*b +: 8];
         endcase
      end
   end
endmodule

// File: rtl/stld_bypass.sv
module stld_bypass #(
   parameter int DATA_BYTES = 8,
   parameter int ROW_BITS   = 6,
   parameter int WAYS       = 2,
   localparam int WAY_BITS  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int DW        = 8 * DATA_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  st_valid,
   input  logic                  st_hit,
   input  logic                  st_zero,
   input  logic [WAY_BITS-1:0]   st_way,
   input  logic [ROW_BITS-1:0]   st_row,
   input  logic [DATA_BYTES-1:0] st_mask,
   input  logic [DW-1:0]         st_data,
   input  logic                  ld_valid,
   input  logic [WAY_BITS-1:0]   ld_way,
   input  logic [ROW_BITS-1:0]   ld_row,
   input  logic [DW-1:0]         ram_rdata,
   output logic                  ld_rvalid,
   output logic [DW-1:0]         ld_data
);
   localparam int SPW = 1 + WAY_BITS + ROW_BITS + DATA_BYTES + DW;
   localparam int LPW = WAY_BITS + ROW_BITS;

   if (DATA_BYTES < 1) begin : g_bad_bytes
      $error("stld_bypass: DATA_BYTES must be at least 1");
   end
   if (ROW_BITS < 1) begin : g_bad_rows
      $error("stld_bypass: ROW_BITS must be at least 1");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("stld_bypass: WAYS must be at least 1");
   end

   logic                  wr_en;
   logic [SPW-1:0]        st_pay;
   logic [SPW-1:0]        old_pay;
   logic                  old_vld;
   logic                  old_zero;
   logic [WAY_BITS-1:0]   old_way;
   logic [ROW_BITS-1:0]   old_row;
   logic [DATA_BYTES-1:0] old_mask;
   logic [DW-1:0]         old_data;
   logic [LPW-1:0]        ld_pay;
   logic [LPW-1:0]        ld_pay_q;
   logic [WAY_BITS-1:0]   q_way;
   logic [ROW_BITS-1:0]   q_row;
   logic [DATA_BYTES-1:0] new_hit;
   logic [DATA_BYTES-1:0] old_hit;

   // Only stores that hit reach the RAM, so only they are tracked.
   assign wr_en  = st_valid && st_hit;
   assign st_pay = {st_zero, st_way, st_row, st_mask, st_data};
   assign ld_pay = {ld_way, ld_row};

   // Write landing at the edge where the load address is sampled.
   stld_pipe_reg #(.W(SPW)) u_old_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (wr_en),
      .in_pay  (st_pay),
      .out_vld (old_vld),
      .out_pay (old_pay)
   );
   assign {old_zero, old_way, old_row, old_mask, old_data} = old_pay;

   // Load address aligned with the registered RAM output.
   stld_pipe_reg #(.W(LPW)) u_load (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (ld_valid),
      .in_pay  (ld_pay),
      .out_vld (ld_rvalid),
      .out_pay (ld_pay_q)
   );
   assign {q_way, q_row} = ld_pay_q;

   stld_match #(.NB(DATA_BYTES), .ROW_BITS(ROW_BITS), .WAYS(WAYS), .WAY_BITS(WAY_BITS)) u_match_new (
      .vld      (wr_en),
      .zero     (st_zero),
      .way      (st_way),
      .row      (st_row),
      .mask     (st_mask),
      .ld_way   (q_way),
      .ld_row   (q_row),
      .byte_hit (new_hit)
   );

   stld_match #(.NB(DATA_BYTES), .ROW_BITS(ROW_BITS), .WAYS(WAYS), .WAY_BITS(WAY_BITS)) u_match_old (
      .vld      (old_vld),
      .zero     (old_zero),
      .way      (old_way),
      .row      (old_row),
      .mask     (old_mask),
      .ld_way   (q_way),
      .ld_row   (q_row),
      .byte_hit (old_hit)
   );

   stld_merge #(.NB(DATA_BYTES)) u_merge (
      .ram_rdata (ram_rdata),
      .old_data  (old_data),
      .new_data  (st_data),
      .old_hit   (old_hit),
      .new_hit   (new_hit),
      .old_zero  (old_zero),
      .new_zero  (st_zero),
      .data      (ld_data)
   );
endmodule

// File: rtl/stld_bypass_chk.sv
module stld_bypass_chk #(
   parameter int DATA_BYTES = 8,
   parameter int ROW_BITS   = 6,
   parameter int WAYS       = 2,
   localparam int WAY_BITS  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int DW        = 8 * DATA_BYTES
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  st_valid,
   input logic                  st_hit,
   input logic                  st_zero,
   input logic [WAY_BITS-1:0]   st_way,
   input logic [ROW_BITS-1:0]   st_row,
   input logic [DATA_BYTES-1:0] st_mask,
   input logic [DW-1:0]         st_data,
   input logic                  ld_valid,
   input logic [WAY_BITS-1:0]   ld_way,
   input logic [ROW_BITS-1:0]   ld_row,
   input logic [DW-1:0]         ram_rdata,
   input logic                  ld_rvalid,
   input logic [DW-1:0]         ld_data
);
   logic                p_ok;
   logic [WAY_BITS-1:0] p_way;
   logic [ROW_BITS-1:0] p_row;
   logic                p_match;
   logic                p_zero;
   logic                p_full;
   logic [DW-1:0]       p_data;
   logic                young_m;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_ok    <= 1'b0;
         p_way   <= '0;
         p_row   <= '0;
         p_match <= 1'b0;
         p_zero  <= 1'b0;
         p_full  <= 1'b0;
         p_data  <= '0;
      end else begin
         p_ok    <= 1'b1;
         p_way   <= ld_way;
         p_row   <= ld_row;
         p_match <= st_valid && st_hit && (st_row == ld_row) && (st_way == ld_way);
         p_zero  <= st_zero;
         p_full  <= &st_mask;
         p_data  <= st_data;
      end
   end

   assign young_m = st_valid && st_hit && (st_row == p_row) && (st_way == p_way);

   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> ld_rvalid); // R1
   AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> !ld_rvalid); // R1
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rvalid && p_ok && !young_m && !p_match) |-> (ld_data == ram_rdata)); // R2
   AST_YOUNG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rvalid && p_ok && young_m && !st_zero && (&st_mask)) |-> (ld_data == st_data)); // R5
   AST_OLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rvalid && p_ok && !young_m && p_match && !p_zero && p_full) |-> (ld_data == p_data)); // R4
   AST_ZERO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rvalid && p_ok && young_m && st_zero) |-> (ld_data == '0)); // R8
endmodule

bind stld_bypass stld_bypass_chk #(
   .DATA_BYTES (DATA_BYTES),
   .ROW_BITS   (ROW_BITS),
   .WAYS       (WAYS)
) u_chk (.*);

// File: tb/stld_bypass_test.sv
module stld_bypass_test;
   localparam int NB   = 4;
   localparam int RB   = 2;
   localparam int WAYS = 2;
   localparam int WB   = 1;
   localparam int DW   = 8 * NB;
   localparam int ENT  = 1 << (RB + WB);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          st_valid, st_hit, st_zero;
   logic [WB-1:0] st_way;
   logic [RB-1:0] st_row;
   logic [NB-1:0] st_mask;
   logic [DW-1:0] st_data;
   logic          ld_valid;
   logic [WB-1:0] ld_way;
   logic [RB-1:0] ld_row;
   logic [DW-1:0] ram_rdata;
   logic          ld_rvalid;
   logic [DW-1:0] ld_data;

   logic [DW-1:0] mem [ENT];
   logic          pv_valid;
   logic [RB+WB-1:0] pv_addr;
   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   stld_bypass #(.DATA_BYTES(NB), .ROW_BITS(RB), .WAYS(WAYS)) uut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_hit(st_hit), .st_zero(st_zero),
      .st_way(st_way), .st_row(st_row), .st_mask(st_mask), .st_data(st_data),
      .ld_valid(ld_valid), .ld_way(ld_way), .ld_row(ld_row), .ram_rdata(ram_rdata),
      .ld_rvalid(ld_rvalid), .ld_data(ld_data));

   function automatic logic [DW-1:0] apply_st(input logic [DW-1:0] old, input logic [NB-1:0] m,
                                              input logic [DW-1:0] d, input logic z);
      logic [DW-1:0] r;
      r = old;
      for (int b = 0; b < NB; b++) begin
         if (z) r[8*b +: 8] = 8'h00;
         else if (m[b]) r[8*b +: 8] = d[8*b +: 8];
      end
      return r;
   endfunction

   // RAM with registered read, read-before-write, hitting stores only.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENT; i++) mem[i] <= 32'h3C00_0000 ^ (i * 32'h0101_0107);
         ram_rdata <= '0;
      end else begin
         ram_rdata <= mem[{ld_way, ld_row}];
         if (st_valid && st_hit)
            mem[{st_way, st_row}] <= apply_st(mem[{st_way, st_row}], st_mask, st_data, st_zero);
      end
   end

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic sv, input logic sh, input logic sz, input logic [WB-1:0] sw,
                        input logic [RB-1:0] sr, input logic [NB-1:0] sm, input logic [DW-1:0] sd,
                        input logic lv, input logic [WB-1:0] lw, input logic [RB-1:0] lr);
      st_valid = sv; st_hit = sh; st_zero = sz; st_way = sw; st_row = sr;
      st_mask = sm; st_data = sd; ld_valid = lv; ld_way = lw; ld_row = lr;
   endtask

   // One cycle: apply inputs, check the load launched last cycle, advance.
   task automatic cycle(input string tag, input logic sv, input logic sh, input logic sz,
                        input logic [WB-1:0] sw, input logic [RB-1:0] sr, input logic [NB-1:0] sm,
                        input logic [DW-1:0] sd, input logic lv, input logic [WB-1:0] lw,
                        input logic [RB-1:0] lr);
      logic [DW-1:0] exp;
      drive(sv, sh, sz, sw, sr, sm, sd, lv, lw, lr);
      #1;
      check({tag, " R1 rvalid"}, DW'(ld_rvalid), DW'(pv_valid));
      if (pv_valid) begin
         exp = mem[pv_addr];
         if (sv && sh && ({sw, sr} == pv_addr)) exp = apply_st(exp, sm, sd, sz);
         check(tag, ld_data, exp);
      end
      pv_valid = lv;
      pv_addr  = {lw, lr};
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      pv_valid = 1'b0;
      pv_addr = '0;
      drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 4'hF, 32'hDEAD_BEEF, 1'b1, 1'b0, 2'd1);
      repeat (3) @(negedge clk);
      check("R1 reset rvalid", DW'(ld_rvalid), '0);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'h0, '0, 1'b0, 1'b0, 2'd0);
      @(negedge clk);
      // R2: plain load, no stores
      cycle("R2", 0, 0, 0, 0, 2'd1, 4'h0, '0, 1, 0, 2'd1);
      cycle("R2", 0, 0, 0, 0, 2'd0, 4'h0, '0, 1, 1, 2'd3);
      // R3: younger store on the port while data is out, partial mask
      cycle("R2", 0, 0, 0, 0, 2'd0, 4'h0, '0, 1, 0, 2'd1);
      cycle("R3", 1, 1, 0, 0, 2'd1, 4'h5, 32'h1122_3344, 0, 0, 2'd0);
      // R4: older store together with the load address
      cycle("R2", 1, 1, 0, 1, 2'd2, 4'hF, 32'hCAFE_F00D, 1, 1, 2'd2);
      cycle("R4", 0, 0, 0, 0, 2'd0, 4'h0, '0, 0, 0, 2'd0);
      cycle("R4", 1, 1, 0, 1, 2'd2, 4'h6, 32'hAABB_CCDD, 1, 1, 2'd2);
      cycle("R4", 0, 0, 0, 0, 2'd0, 4'h0, '0, 0, 0, 2'd0);
      // R5: overlapping older and younger stores
      cycle("R2", 1, 1, 0, 0, 2'd3, 4'h3, 32'h0102_0304, 1, 0, 2'd3);
      cycle("R5", 1, 1, 0, 0, 2'd3, 4'h6, 32'hA0B0_C0D0, 0, 0, 2'd0);
      cycle("R2", 1, 1, 0, 0, 2'd3, 4'hF, 32'h5555_AAAA, 1, 0, 2'd3);
      cycle("R5", 1, 1, 0, 0, 2'd3, 4'h9, 32'h7788_99EE, 0, 0, 2'd0);
      // R6: stores that miss are not forwarded
      cycle("R2", 1, 0, 0, 0, 2'd0, 4'hF, 32'hFFFF_FFFF, 1, 0, 2'd0);
      cycle("R6", 1, 0, 0, 0, 2'd0, 4'hF, 32'hEEEE_EEEE, 0, 0, 2'd0);
      // R7: same row, different way
      cycle("R2", 1, 1, 0, 0, 2'd1, 4'hF, 32'h0F0F_0F0F, 1, 1, 2'd1);
      cycle("R7", 1, 1, 0, 0, 2'd1, 4'hF, 32'hF0F0_F0F0, 0, 0, 2'd0);
      // R8: zeroing stores, older then younger
      cycle("R2", 1, 1, 1, 0, 2'd2, 4'h1, 32'h1234_5678, 1, 0, 2'd2);
      cycle("R8", 0, 0, 0, 0, 2'd0, 4'h0, '0, 0, 0, 2'd0);
      cycle("R2", 1, 1, 0, 1, 2'd3, 4'hF, 32'h9999_8888, 1, 1, 2'd3);
      cycle("R8", 1, 1, 1, 1, 2'd3, 4'h0, 32'h4444_3333, 0, 0, 2'd0);
      cycle("R2", 1, 1, 1, 0, 2'd1, 4'h2, '0, 1, 0, 2'd1);
      cycle("R8", 1, 1, 0, 0, 2'd1, 4'h4, 32'h00AB_0000, 0, 0, 2'd0);
      // R9: sweep over the small row and way space
      for (int i = 0; i < 6000; i++) begin
         cycle("R9", ($urandom % 4) != 0, ($urandom % 5) != 0, ($urandom % 9) == 0,
               WB'($urandom), RB'($urandom), NB'($urandom), DW'($urandom),
               ($urandom % 4) != 0, WB'($urandom), RB'($urandom));
      end
      cycle("R9", 0, 0, 0, 0, 2'd0, 4'h0, '0, 0, 0, 2'd0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule